// File: doc/BRIEF.md
# Saturating Per-Stream Error Counter Bank

This block keeps one error tally for each of 96 serial input streams. An upstream bit-error detector presents a vector of per-stream strobes every clock. Each asserted strobe adds one to the tally of its stream, and any number of streams may count in the same cycle. A tally stops at its largest value instead of wrapping, so a saturated reading means "at least this many".

A host reaches the tallies through a small word-wide bus with byte enables. A read returns the selected tally in the low half of a 32-bit word, and the upper half is always zero. A write clears the selected tally. The write data does not matter, and a write that enables only the upper, unused byte lanes still clears it. The streams are arranged as groups of four, lettered A to D. Every letter has its own 128-byte window, and each group takes one 32-bit word inside that window.

Top module: `errbank_top`

## Requirements
- R1: Stream s is group g = s / 4 and letter l = s % 4 (A=0, B=1, C=2, D=3). While strobe bit s is high at a rising clock edge, the tally of stream s grows by one at that edge. All streams count independently, and they may all count in the same cycle.
- R2: A read returns the tally in read-data bits 15:0. Bits 31:16 are always zero.
- R3: A tally that has reached 65535 stays at 65535 under further strobes until it is cleared.
- R4: A write whose byte-enable vector is nonzero clears the whole addressed tally, whatever lanes are enabled, including a write that enables only lanes 3 and 2. A write with all byte enables low changes nothing.
- R5: When a clearing write and a strobe reach the same stream in the same cycle, the clear takes effect and the tally reads zero afterwards.
- R6: Byte address = letter × 0x80 + group × 4. Letter A is at 0x000, B at 0x080, C at 0x100 and D at 0x180. The bus carries only address bits 9:2.
- R7: Read data is registered. It shows the addressed tally one clock after the read strobe, and it keeps its value while no read is strobed.
- R8: Offsets 0x60 to 0x7F inside any letter window, and every byte address of 0x200 or above, read as zero. Writes to those addresses clear nothing.
- R9: An active-low reset clears every tally and the read data.
- R10: A tally with neither a strobe nor a clearing write keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_strobe | input | 96 | Per-stream error strobes, bit s for stream s |
| bus_sel | input | 1 | Host access strobe |
| bus_wr | input | 1 | 1 = write (clear), 0 = read |
| bus_be | input | 4 | Byte-lane enables for writes |
| bus_addr | input | 8 | Word address, byte-address bits 9:2 |
| bus_rdata | output | 32 | Registered read data |

## Verification
The bench builds the block with its default parameters: 24 groups, 16-bit tallies and a 10-bit byte address. Because the tallies are 16 bits wide, driving one strobe continuously for a little over 65536 cycles reaches the saturation point well within the run length. The 10-bit address space extends past the 0x200 boundary, so addresses above the map can be exercised. In particular, the bench checks that an address which would alias onto group 0 under truncation neither reads nor clears that tally. Group 24 of each letter falls inside the unused 0x60 to 0x7F band, which makes that band testable as well.

// File: rtl/errbank_pkg.sv
package errbank_pkg;
  localparam int DATA_W   = 32;
  localparam int LANES    = DATA_W / 8;
  localparam int LETTERS  = 4;
  localparam int LETTER_W = 2;
  localparam int WIN_SH   = 7;   // 128-byte letter window
  localparam int GRP_W    = WIN_SH - 2;
  localparam int MAP_SH   = WIN_SH + LETTER_W; // 0x200 total map

  typedef enum logic [LETTER_W-1:0] {
    LTR_A = 2'd0,
    LTR_B = 2'd1,
    LTR_C = 2'd2,
    LTR_D = 2'd3
  } letter_e;
endpackage

// File: rtl/errbank_decode.sv
module errbank_decode
  import errbank_pkg::*;
#(
  parameter int GROUPS  = 24,
  parameter int ADDR_W  = 10,
  parameter int STREAMS = 4 * GROUPS,
  parameter int IDX_W   = $clog2(STREAMS)
) (
  input  logic [ADDR_W-1:2]  addr,
  input  logic               sel,
  input  logic               wr,
  input  logic [LANES-1:0]   be,
  output logic               hit,
  output logic [IDX_W-1:0]   idx,
  output logic               rd_en,
  output logic [STREAMS-1:0] clr_vec
);
  localparam int WIDE_W = IDX_W + 3;

  letter_e          letter;
  logic [GRP_W-1:0] group;
  logic             above_map;
  logic             grp_ok;
  logic             wr_any;
  logic [WIDE_W-1:0] idx_wide;

  assign letter = letter_e'(addr[MAP_SH-1:WIN_SH]);
  assign group  = addr[WIN_SH-1:2];

  generate
    if (ADDR_W > MAP_SH) begin : g_upper
      assign above_map = |addr[ADDR_W-1:MAP_SH];
    end else begin : g_no_upper
      assign above_map = 1'b0;
    end
  endgenerate

  always_comb begin
    grp_ok   = (32'(group) < 32'(GROUPS));
    hit      = grp_ok && !above_map;
    idx_wide = (WIDE_W'(group) << 2) | WIDE_W'(letter);
    idx      = idx_wide[IDX_W-1:0];
    rd_en    = sel && !wr;
    wr_any   = sel && wr && (|be) && hit;
  end

  generate
    for (genvar s = 0; s < STREAMS; s++) begin : g_clr
      assign clr_vec[s] = wr_any && (idx == IDX_W'(s));
    end
  endgenerate
endmodule

// File: rtl/errbank_cell.sv
module errbank_cell #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             err,
  input  logic             clr,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;
  logic             at_max;

  always_comb begin
    at_max = &cnt_q;
    cnt_en = clr || (err && !at_max);
    if (clr) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/errbank_rdport.sv
module errbank_rdport
  import errbank_pkg::*;
#(
  parameter int STREAMS = 96,
  parameter int CNT_W   = 16,
  parameter int IDX_W   = $clog2(STREAMS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [STREAMS*CNT_W-1:0] counts,
  input  logic                     rd_en,
  input  logic                     hit,
  input  logic [IDX_W-1:0]         idx,
  output logic [DATA_W-1:0]        rdata
);
  logic [CNT_W-1:0]  picked;
  logic [DATA_W-1:0] rdata_d;
  logic [DATA_W-1:0] rdata_q;

  always_comb begin
    picked = '0;
    for (int s = 0; s < STREAMS; s++) begin
      if (idx == IDX_W'(s)) begin
        picked = counts[s*CNT_W +: CNT_W];
      end
    end
    rdata_d = hit ? DATA_W'(picked) : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rdata_d;
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/errbank_top.sv
module errbank_top
  import errbank_pkg::*;
#(
  parameter int GROUPS = 24,
  parameter int CNT_W  = 16,
  parameter int ADDR_W = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [4*GROUPS-1:0]   err_strobe,
  input  logic                  bus_sel,
  input  logic                  bus_wr,
  input  logic [LANES-1:0]      bus_be,
  input  logic [ADDR_W-1:2]     bus_addr,
  output logic [DATA_W-1:0]     bus_rdata
);
  localparam int STREAMS = LETTERS * GROUPS;
  localparam int IDX_W   = $clog2(STREAMS);

  logic                     hit;
  logic [IDX_W-1:0]         idx;
  logic                     rd_en;
  logic [STREAMS-1:0]       clr_vec;
  logic [STREAMS*CNT_W-1:0] cnt_flat;

  errbank_decode #(
    .GROUPS (GROUPS),
    .ADDR_W (ADDR_W),
    .STREAMS(STREAMS),
    .IDX_W  (IDX_W)
  ) u_decode (
    .addr   (bus_addr),
    .sel    (bus_sel),
    .wr     (bus_wr),
    .be     (bus_be),
    .hit    (hit),
    .idx    (idx),
    .rd_en  (rd_en),
    .clr_vec(clr_vec)
  );

  generate
    for (genvar s = 0; s < STREAMS; s++) begin : g_cell
      errbank_cell #(.CNT_W(CNT_W)) u_cell (
        .clk  (clk),
        .rst_n(rst_n),
        .err  (err_strobe[s]),
        .clr  (clr_vec[s]),
        .count(cnt_flat[s*CNT_W +: CNT_W])
      );
    end
  endgenerate

  errbank_rdport #(
    .STREAMS(STREAMS),
    .CNT_W  (CNT_W),
    .IDX_W  (IDX_W)
  ) u_rdport (
    .clk   (clk),
    .rst_n (rst_n),
    .counts(cnt_flat),
    .rd_en (rd_en),
    .hit   (hit),
    .idx   (idx),
    .rdata (bus_rdata)
  );
endmodule

// File: rtl/errbank_chk.sv
module errbank_chk
  import errbank_pkg::*;
#(
  parameter int GROUPS = 24,
  parameter int CNT_W  = 16
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic [4*GROUPS-1:0]           err_strobe,
  input logic [4*GROUPS-1:0]           clr_vec,
  input logic [4*GROUPS*CNT_W-1:0]     cnt_flat,
  input logic                          rd_en,
  input logic                          hit,
  input logic [DATA_W-1:0]             bus_rdata
);
  localparam int STREAMS = 4 * GROUPS;
  localparam logic [CNT_W-1:0] TOP = '1;

  // R2: upper half never carries data
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:CNT_W] == '0);

  // R8: reads outside the map return zero
  p_miss_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !hit) |=> (bus_rdata == '0));

  // R7: read data holds without a read strobe
  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(bus_rdata));

  // R4/R5: at most one tally is cleared per access
  p_one_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_vec));

  generate
    for (genvar s = 0; s < STREAMS; s++) begin : g_cell_chk
      // R5: clear wins, tally is zero afterwards
      p_clear_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr_vec[s] |=> (cnt_flat[s*CNT_W +: CNT_W] == '0));
      // R3: saturated tally holds
      p_sat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_vec[s] && cnt_flat[s*CNT_W +: CNT_W] == TOP)
          |=> (cnt_flat[s*CNT_W +: CNT_W] == TOP));
      // R1: a strobe below the ceiling adds exactly one
      p_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_vec[s] && err_strobe[s] && cnt_flat[s*CNT_W +: CNT_W] != TOP)
          |=> (cnt_flat[s*CNT_W +: CNT_W] ==
               CNT_W'($past(cnt_flat[s*CNT_W +: CNT_W]) + CNT_W'(1))));
      // R10: idle tally is stable
      p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_vec[s] && !err_strobe[s]) |=> $stable(cnt_flat[s*CNT_W +: CNT_W]));
    end
  endgenerate
endmodule

bind errbank_top errbank_chk #(.GROUPS(GROUPS), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .err_strobe(err_strobe),
  .clr_vec   (clr_vec),
  .cnt_flat  (cnt_flat),
  .rd_en     (rd_en),
  .hit       (hit),
  .bus_rdata (bus_rdata)
);

// File: tb/errbank_top_bench.sv
`timescale 1ns/1ps
module errbank_top_bench;
  localparam int GROUPS  = 24;
  localparam int STREAMS = 4 * GROUPS;
  localparam int MAXV    = 65535;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [STREAMS-1:0] err_strobe = '0;
  logic               bus_sel = 1'b0;
  logic               bus_wr = 1'b0;
  logic [3:0]         bus_be = '0;
  logic [9:2]         bus_addr = '0;
  logic [31:0]        bus_rdata;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 1'b0;
  int model [STREAMS];

  // stream, pulse count
  localparam int TV [0:7][0:1] = '{
    '{0, 3}, '{1, 5}, '{2, 1}, '{3, 2},
    '{4, 7}, '{50, 4}, '{95, 9}, '{0, 2}
  };

  errbank_top u_errbank_top (
    .clk(clk), .rst_n(rst_n), .err_strobe(err_strobe),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_be(bus_be),
    .bus_addr(bus_addr), .bus_rdata(bus_rdata)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      checks++; failures++;
      $display("FAIL watchdog: cycles=%0d expected finish before 150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  function automatic logic [9:2] word_of(int s);
    int byte_addr;
    byte_addr = (s % 4) * 128 + (s / 4) * 4; // R6 map
    return byte_addr[9:2];
  endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic read_word(logic [9:2] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    d = bus_rdata;
  endtask

  task automatic read_check(int s, string req);
    logic [31:0] d;
    read_word(word_of(s), d);
    check(req, int'(d), model[s]);
    check("R2", int'(d[31:16]), 0);
  endtask

  task automatic write_word(logic [9:2] a, logic [3:0] be);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_be = be;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic pulse(logic [STREAMS-1:0] v, int n);
    @(negedge clk);
    err_strobe = v;
    repeat (n) @(negedge clk);
    err_strobe = '0;
    for (int s = 0; s < STREAMS; s++)
      if (v[s]) model[s] = (model[s] + n > MAXV) ? MAXV : model[s] + n;
  endtask

  initial begin
    logic [31:0] d;
    logic [31:0] held;
    for (int s = 0; s < STREAMS; s++) model[s] = 0;
    repeat (3) @(negedge clk);
    check("R9", int'(bus_rdata), 0);
    rst_n = 1'b1;
    read_check(0, "R9");
    read_check(95, "R9");

    // table walk (R1, R6)
    for (int i = 0; i < 8; i++) begin
      pulse(STREAMS'(1) << TV[i][0], TV[i][1]);
      read_check(TV[i][0], "R1");
    end
    read_check(1, "R6");
    read_check(50, "R6");

    // all streams together (R1)
    pulse('1, 2);
    read_check(7, "R1");
    read_check(95, "R1");
    read_check(0, "R1");

    // registered read and hold (R7)
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = word_of(95);
    held = bus_rdata;
    #1 check("R7", int'(bus_rdata), int'(held));
    @(negedge clk);
    bus_sel = 1'b0;
    check("R7", int'(bus_rdata), model[95]);
    held = bus_rdata;
    pulse(STREAMS'(1) << 95, 3);
    check("R7", int'(bus_rdata), int'(held));
    read_check(95, "R7");

    // clears (R4)
    write_word(word_of(4), 4'b0000);
    read_check(4, "R4");
    write_word(word_of(4), 4'b1100);
    model[4] = 0;
    read_check(4, "R4");
    write_word(word_of(50), 4'b0001);
    model[50] = 0;
    read_check(50, "R4");
    read_check(51, "R10");

    // clear versus strobe same cycle (R5)
    @(negedge clk);
    err_strobe = STREAMS'(1) << 1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = word_of(1); bus_be = 4'b1111;
    @(negedge clk);
    err_strobe = '0; bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
    model[1] = 0;
    read_check(1, "R5");

    // unmapped addresses (R8)
    read_word(8'h18, d);            // letter A, group 24 (0x060)
    check("R8", int'(d), 0);
    read_word(8'h7F, d);            // 0x1FC, letter D group 31
    check("R8", int'(d), 0);
    read_word(8'h80, d);            // 0x200 would alias stream 0
    check("R8", int'(d), 0);
    write_word(8'h80, 4'b1111);
    write_word(8'h18, 4'b1111);
    read_check(0, "R8");
    read_check(95, "R8");

    // saturation (R3)
    pulse(STREAMS'(1) << 7, 65540);
    read_check(7, "R3");
    pulse(STREAMS'(1) << 7, 4);
    read_check(7, "R3");
    write_word(word_of(7), 4'b1000);
    model[7] = 0;
    read_check(7, "R3");

    // reset mid-run (R9)
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R9", int'(bus_rdata), 0);
    rst_n = 1'b1;
    for (int s = 0; s < STREAMS; s++) model[s] = 0;
    read_check(0, "R9");
    read_check(95, "R9");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule